// File: doc/BRIEF.md
# Level Interrupt Aggregator with Dual Request and Dual Machine-Check Outputs

This block gathers a vector of level-sensitive, active-high interrupt sources into a single read-only status word. Four outputs are derived from that word: two interrupt request lines and two machine-check lines. Each output has its own enable mask register. An output is high when at least one enabled source is high. The block does no arbitration between the outputs, so a source enabled in several masks drives all of those outputs at the same time.

Source levels pass through a two-stage synchronizer before they reach the status word. Source positions that are configured as unused always read as zero. A small word-addressed register port is used to read the status word and to read and write the four masks. Interrupts are not acknowledged in the block. A request drops only when its source lowers its level or when software clears the enable bit.

Top module: `lvl_irq_aggregator`

## Requirements
- R1: After reset all four mask registers read 0, both `irq_req` bits and both `mchk_req` bits are 0, and `bus_rdata` is 0.
- R2: Word address 0 returns the status word. Each bit is the level of its source, seen two clock edges after the source changes. Bits outside `LIVE_MASK` (default bits 17 to 31) always read 0 and never drive an output.
- R3: Word addresses 4, 5, 6 and 7 hold, in that order, the request mask for line 0, the request mask for line 1, the machine-check mask for line 0 and the machine-check mask for line 1. Each one reads back the last value written to it.
- R4: `irq_req[n]` is a register holding the OR of (status AND request mask n). It changes on the clock edge after the edge that updates the status word or the mask.
- R5: `mchk_req[n]` follows the same rule as R4 using machine-check mask n, with the same one-edge delay.
- R6: A source that is enabled in more than one mask raises every one of those outputs on the same edge.
- R7: A write to address 0 or to an unmapped address (1 to 3, 8 to 15) changes no register. A read of an unmapped address returns 0.
- R8: Outputs are level-following and never latch. When every enabled source goes low, the output falls, with the same latency as it rose.
- R9: A read request (`bus_sel`=1, `bus_wr`=0) that is sampled on an edge puts its data on `bus_rdata` after that edge. The value holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_lvl | input | 32 | Interrupt source levels, active high |
| irq_req | output | 2 | Interrupt request lines 0 and 1 |
| mchk_req | output | 2 | Machine-check lines 0 and 1 |

## Verification
The bench targets the latency chain: the status word must appear exactly two edges after a source changes, and the output one edge after that. A design with a missing synchronizer stage, or with combinational outputs, would assert a cycle early. Reserved source positions are driven high while every mask enables them. A design that does not clear those bits would show nonzero status and spurious requests. The bench also writes to the status address and to holes in the map, then reads the masks back. A design that decodes loosely would corrupt a mask or return stale data from a hole. Finally, one source enabled on all four outputs must raise all four together, and the outputs must drop again when the source falls. A design that latched requests or kept the routes exclusive would fail one of these checks.

// File: rtl/agg_pkg.sv
package agg_pkg;
   localparam int ADDR_STATUS = 0;
   localparam int MASK_BASE   = 4;
   localparam int NUM_MASK    = 4;   // request 0, request 1, machine-check 0, machine-check 1
   localparam int IDX_IRQ0    = 0;
   localparam int IDX_MCHK0   = 2;

   function automatic logic addr_is_mask(input int unsigned a);
      return (a >= MASK_BASE) && (a < MASK_BASE + NUM_MASK);
   endfunction
endpackage

// File: rtl/agg_sync.sv
module agg_sync #(
   parameter int                WIDTH     = 32,
   parameter int                STAGES    = 2,
   parameter logic [WIDTH-1:0]  LIVE_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("agg_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      chain_q[s] <= '0;
         else if (s == 0) chain_q[s] <= async_i & LIVE_MASK;
         else             chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/agg_mask_bank.sv
module agg_mask_bank #(
   parameter int WIDTH    = 32,
   parameter int ADDR_W   = 4,
   parameter int BASE     = 4,
   parameter int NUM_MASK = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [WIDTH-1:0]                 wdata,
   output logic [NUM_MASK-1:0][WIDTH-1:0]   mask_o,
   output logic [WIDTH-1:0]                 rd_o
);
   if (BASE + NUM_MASK > (1 << ADDR_W)) begin : g_bad_map
      $error("agg_mask_bank: mask window exceeds address space");
   end

   for (genvar i = 0; i < NUM_MASK; i++) begin : g_mask
      logic hit;
      assign hit = wr_en && (int'(addr) == BASE + i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   mask_o[i] <= '0;
         else if (hit) mask_o[i] <= wdata;
      end
   end

   always_comb begin
      rd_o = '0;
      for (int i = 0; i < NUM_MASK; i++)
         if (int'(addr) == BASE + i) rd_o = mask_o[i];
   end
endmodule

// File: rtl/agg_out_bank.sv
module agg_out_bank #(
   parameter int WIDTH = 32,
   parameter int LINES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [WIDTH-1:0]              stat_i,
   input  logic [LINES-1:0][WIDTH-1:0]   mask_i,
   output logic [LINES-1:0]              req_o
);
   if (LINES < 1) begin : g_bad_lines
      $error("agg_out_bank: LINES must be at least 1");
   end

   for (genvar n = 0; n < LINES; n++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_o[n] <= 1'b0;
         else        req_o[n] <= |(stat_i & mask_i[n]);
      end

      AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_i[n] == '0) |=> !req_o[n]);  // R4
      AST_LEVEL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_i == '0) |=> !req_o[n]);  // R8
   end
endmodule

// File: rtl/lvl_irq_aggregator.sv
module lvl_irq_aggregator #(
   parameter int                 NUM_SRC    = 32,
   parameter int                 DATA_W     = 32,
   parameter int                 ADDR_W     = 4,
   parameter int                 SYNC_STAGES = 2,
   parameter logic [NUM_SRC-1:0] LIVE_MASK  = 32'h0001_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_SRC-1:0] src_lvl,
   output logic [1:0]        irq_req,
   output logic [1:0]        mchk_req
);
   import agg_pkg::*;

   localparam int LINES = NUM_MASK / 2;

   if (NUM_SRC > DATA_W) begin : g_bad_width
      $error("lvl_irq_aggregator: NUM_SRC must not exceed DATA_W");
   end

   logic [NUM_SRC-1:0]                 status;
   logic [NUM_MASK-1:0][NUM_SRC-1:0]   mask_all;
   logic [NUM_SRC-1:0]                 mask_rd;
   logic [DATA_W-1:0]                  rd_nxt;
   logic                               wr_en, rd_en;

   assign wr_en = bus_sel &&  bus_wr;
   assign rd_en = bus_sel && !bus_wr;

   agg_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES), .LIVE_MASK(LIVE_MASK)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(src_lvl), .sync_o(status));

   agg_mask_bank #(.WIDTH(NUM_SRC), .ADDR_W(ADDR_W), .BASE(MASK_BASE), .NUM_MASK(NUM_MASK)) u_masks (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
      .wdata(bus_wdata[NUM_SRC-1:0]), .mask_o(mask_all), .rd_o(mask_rd));

   agg_out_bank #(.WIDTH(NUM_SRC), .LINES(LINES)) u_irq (
      .clk(clk), .rst_n(rst_n), .stat_i(status),
      .mask_i(mask_all[IDX_IRQ0+LINES-1:IDX_IRQ0]), .req_o(irq_req));

   agg_out_bank #(.WIDTH(NUM_SRC), .LINES(LINES)) u_mchk (
      .clk(clk), .rst_n(rst_n), .stat_i(status),
      .mask_i(mask_all[IDX_MCHK0+LINES-1:IDX_MCHK0]), .req_o(mchk_req));

   always_comb begin
      rd_nxt = '0;
      if (int'(bus_addr) == ADDR_STATUS)        rd_nxt[NUM_SRC-1:0] = status;
      else if (addr_is_mask(int'(bus_addr)))    rd_nxt[NUM_SRC-1:0] = mask_rd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_en) bus_rdata <= rd_nxt;
   end

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~LIVE_MASK) == '0);  // R2
   AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(bus_addr) == ADDR_STATUS) |=> $stable(mask_all));  // R7
   AST_HOLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && int'(bus_addr) != ADDR_STATUS && !addr_is_mask(int'(bus_addr))) |=> bus_rdata == '0);  // R7
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |=> $stable(bus_rdata));  // R9
endmodule

// File: tb/tb_lvl_irq_aggregator.sv
module tb_lvl_irq_aggregator;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 6;

   localparam logic [31:0] V_SRC [NV] = '{32'h0000_0001, 32'h0001_0000, 32'hFFFF_FFFF,
                                          32'h0000_0080, 32'h0000_0F00, 32'h1234_5678};
   localparam logic [31:0] V_MI0 [NV] = '{32'h1, 32'h0, 32'hFFFE_0000, 32'h80, 32'h0000_F0FF, 32'hFFFF_FFFF};
   localparam logic [31:0] V_MI1 [NV] = '{32'h0, 32'h0001_0000, 32'hFFFE_0000, 32'h80, 32'h100, 32'h0};
   localparam logic [31:0] V_MC0 [NV] = '{32'h0, 32'h0001_0000, 32'hFFFE_0000, 32'h80, 32'h0, 32'h0001_0000};
   localparam logic [31:0] V_MC1 [NV] = '{32'h0, 32'h0, 32'hFFFE_0000, 32'h80, 32'h800, 32'h8};
   localparam logic [1:0]  V_IRQ [NV] = '{2'b01, 2'b10, 2'b00, 2'b11, 2'b10, 2'b01};
   localparam logic [1:0]  V_MCK [NV] = '{2'b00, 2'b01, 2'b00, 2'b11, 2'b10, 2'b10};
   localparam logic [31:0] V_STA [NV] = '{32'h1, 32'h0001_0000, 32'h0001_FFFF, 32'h80, 32'hF00, 32'h5678};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata, src_lvl = '0;
   logic [1:0]  irq_req, mchk_req;
   int          n_chk = 0, n_fail = 0;
   logic [31:0] rv;

   always #(CLK_PERIOD/2) clk = ~clk;

   lvl_irq_aggregator dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_lvl(src_lvl),
      .irq_req(irq_req), .mchk_req(mchk_req));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(posedge clk); @(negedge clk);
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      tick(2);
      // R1: outputs and read data idle in and out of reset
      chk("R1 irq", {30'b0, irq_req}, 32'h0);
      chk("R1 mchk", {30'b0, mchk_req}, 32'h0);
      chk("R1 rdata", bus_rdata, 32'h0);
      rst_n = 1'b1;
      tick(1);
      for (int a = 4; a < 8; a++) begin
         rd(4'(a), rv); chk("R1 mask reset", rv, 32'h0);
      end

      // vector table: R2 R3 R4 R5 R6
      for (int v = 0; v < NV; v++) begin
         wr(4'd4, V_MI0[v]); wr(4'd5, V_MI1[v]); wr(4'd6, V_MC0[v]); wr(4'd7, V_MC1[v]);
         src_lvl = V_SRC[v];
         tick(4);
         chk("R4 irq vec", {30'b0, irq_req}, {30'b0, V_IRQ[v]});
         chk("R5 mchk vec", {30'b0, mchk_req}, {30'b0, V_MCK[v]});
         rd(4'd0, rv); chk("R2 status vec", rv, V_STA[v]);
         rd(4'd4, rv); chk("R3 mask0 readback", rv, V_MI0[v]);
         rd(4'd7, rv); chk("R3 mchk1 readback", rv, V_MC1[v]);
      end

      // R6: one source on all four outputs together
      src_lvl = '0;
      wr(4'd4, 32'h4); wr(4'd5, 32'h4); wr(4'd6, 32'h4); wr(4'd7, 32'h4);
      tick(4);
      src_lvl = 32'h4;
      tick(3);
      chk("R6 all rise together", {28'b0, mchk_req, irq_req}, 32'hF);

      // R4 / R8 latency: rise three edges after source, fall likewise
      wr(4'd5, 32'h0); wr(4'd6, 32'h0); wr(4'd7, 32'h0);
      wr(4'd4, 32'h1);
      src_lvl = 32'h0;
      tick(4);
      src_lvl = 32'h1;
      tick(2);
      chk("R4 not yet after 2 edges", {31'b0, irq_req[0]}, 32'h0);
      tick(1);
      chk("R4 rise after 3 edges", {31'b0, irq_req[0]}, 32'h1);
      src_lvl = 32'h0;
      tick(2);
      chk("R8 still high after 2 edges", {31'b0, irq_req[0]}, 32'h1);
      tick(1);
      chk("R8 fall after 3 edges", {31'b0, irq_req[0]}, 32'h0);

      // R5: mask write takes effect one edge after the write edge
      src_lvl = 32'h2;
      tick(4);
      wr(4'd6, 32'h2);
      chk("R5 not yet at write edge", {31'b0, mchk_req[0]}, 32'h0);
      tick(1);
      chk("R5 one edge after write", {31'b0, mchk_req[0]}, 32'h1);

      // R7: writes to status and holes ignored, holes read 0
      wr(4'd0, 32'hFFFF_FFFF);
      wr(4'd2, 32'hDEAD_BEEF);
      wr(4'd9, 32'h1234_5678);
      rd(4'd4, rv); chk("R7 mask0 untouched", rv, 32'h1);
      rd(4'd6, rv); chk("R7 mchk0 untouched", rv, 32'h2);
      rd(4'd0, rv); chk("R7 status still live", rv, 32'h2);
      rd(4'd2, rv); chk("R7 hole reads 0", rv, 32'h0);
      rd(4'd15, rv); chk("R7 top hole reads 0", rv, 32'h0);

      // R9: read data valid after the sampling edge and held afterwards
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd6;
      @(posedge clk); #1;
      chk("R9 data after edge", bus_rdata, 32'h2);
      bus_sel = 1'b0; bus_addr = 4'd4;
      tick(2);
      chk("R9 data held", bus_rdata, 32'h2);

      finish_run();
   end
endmodule